// File: doc/BRIEF.md
# Four-Channel DAC Register Bank

This block is a bus-slave register bank for four independent 12-bit DAC channels. Each channel owns one control word and one data word, and both sit on a simple request/write-enable bus with combinational readback. From these registers the block produces, for each channel, a 12-bit output code, a 2-bit range select and an output-enable. The analog side, which covers the resistor string, the buffer and the references, lies outside the block and consumes these signals.

A data write first lands in a pending register. Each channel then has one of two update sources. In immediate mode the output code follows the pending value one core clock later. In timer mode the pending value is copied to the output only in a cycle where the single-cycle `tick_i` strobe is high. Each channel also has an active-low clear bit, which holds both the pending register and the output code at zero. A range code of 00 selects power-down and drops the output-enable.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After reset, every control and data register reads 0, and every channel drives code 0, range 00 and output-enable 0.
- R2: The register of channel c is decoded from the byte address. The control word is at 8*c and the data word is at 8*c+4. Control bits [5], [4] and [1:0] are stored and read back at the same positions.
- R3: Reserved bits read as 0, and writes to them are ignored. In the control word these are bits [31:6] and [3:2]. In the data word these are bits [31:28] and [15:0]. The code is held in data bits [27:16].
- R4: The clear bit is control bit [4] and is active low. It takes effect from the clock edge that stores it. From the following clock edge onward, the channel's data register reads 0 and its code output is 0. A data write accepted while the stored clear bit is 0 has no effect.
- R5: In immediate mode, control bit [5] is 0. A data write stored at edge N appears on the channel's code output at edge N+1.
- R6: In timer mode, control bit [5] is 1. The code output holds its value until an edge at which `tick_i` is high, and at that edge it loads the pending value. If several writes arrive between two strobes, only the last one is kept.
- R7: A data write and a `tick_i` strobe can fall on the same edge in timer mode. At that edge the output loads the pending value held before the edge, and the new value stays pending until the next strobe.
- R8: The range output equals control bits [1:0]. The encodings are 00 for power-down, 01 for the external reference, 10 for the internal reference and 11 for the supply. Output-enable is 0 exactly when the range is 00.
- R9: Some accesses fall outside the map: a byte offset of 0x20 or more, or an address whose bits [1:0] are not 00. Such an access reads 0, and a write to it changes no register.
- R10: Channels are independent. A write or strobe that affects one channel leaves the registers and outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable, 1 = write |
| addr_i | input | 6 | Byte address within the block window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i is high and we_i is low |
| tick_i | input | 1 | Single-cycle timer strobe shared by all channels |
| code_o | output | 48 | Output code; channel c occupies bits [12c+11:12c] |
| range_o | output | 8 | Range select; channel c occupies bits [2c+1:2c] |
| oe_o | output | 4 | Output-enable, one bit per channel |

## Verification
The collision that matters is between a bus write to a timer-mode channel's data word and a timer strobe arriving in the same cycle. The bench provokes it by driving the write and `tick_i` on the same falling edge. It then checks that the output shows the value pending before that edge, that the data word reads back the new value, and that the new value reaches the output only at the next strobe. A second overlap arises between a clear written through the control word and the update path. The bench checks that a channel in timer mode drops to zero without any strobe.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned CTRL_UPD_BIT = 5;
  localparam int unsigned CTRL_CLR_BIT = 4;
  localparam int unsigned CTRL_RNG_LSB = 0;
  localparam int unsigned CTRL_W       = 8;
  localparam int unsigned CH_STRIDE_LSB = 3;  // 8-byte stride per channel
  localparam int unsigned SEL_DATA_BIT  = 2;  // +4 selects data word

  typedef enum logic [1:0] {
    RNG_OFF = 2'b00,
    RNG_EXT = 2'b01,
    RNG_INT = 2'b10,
    RNG_SUP = 2'b11
  } rng_e;

  typedef struct packed {
    logic upd;
    logic clr_n;
    rng_e rng;
  } ctrl_t;
endpackage

// File: rtl/dac_bank_decode.sv
module dac_bank_decode
  import dac_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              is_data_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [NCH-1:0]    ctrl_we_o,
  output logic [NCH-1:0]    data_we_o
);
  localparam int unsigned IDX_W = ADDR_W - CH_STRIDE_LSB;

  logic [IDX_W-1:0] slot;
  logic             aligned;

  assign slot      = addr_i[ADDR_W-1:CH_STRIDE_LSB];
  assign aligned   = (addr_i[1:0] == 2'b00);
  assign hit_o     = aligned && (int'(slot) < int'(NCH));
  assign is_data_o = addr_i[SEL_DATA_BIT];
  assign ch_o      = addr_i[CH_STRIDE_LSB +: CH_W];

  for (genvar c = 0; c < NCH; c++) begin : g_we
    logic sel;
    assign sel          = req_i && we_i && hit_o && (ch_o == CH_W'(c));
    assign ctrl_we_o[c] = sel && !is_data_o;
    assign data_we_o[c] = sel &&  is_data_o;
  end
endmodule

// File: rtl/dac_bank_chan.sv
module dac_bank_chan
  import dac_bank_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  ctrl_t             ctrl_i,
  input  logic              data_we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output ctrl_t             ctrl_o,
  output logic [CODE_W-1:0] pend_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        range_o,
  output logic              oe_o
);
  ctrl_t             ctrl_q;
  logic [CODE_W-1:0] pend_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_i;
  end

  // clear dominates; writes during clear are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pend_q <= '0;
    else if (!ctrl_q.clr_n) pend_q <= '0;
    else if (data_we_i)     pend_q <= code_i;
  end

  // timer mode loads the pre-edge pending value on a strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     code_q <= '0;
    else if (!ctrl_q.clr_n)          code_q <= '0;
    else if (!ctrl_q.upd || tick_i)  code_q <= pend_q;
  end

  assign ctrl_o  = ctrl_q;
  assign pend_o  = pend_q;
  assign code_o  = code_q;
  assign range_o = ctrl_q.rng;
  assign oe_o    = (ctrl_q.rng != RNG_OFF);

  p_clr_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.clr_n |=> (pend_q == '0) && (code_q == '0));

  p_imm_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.clr_n && !ctrl_q.upd) |=> (code_q == $past(pend_q)));

  p_tmr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.clr_n && ctrl_q.upd && !tick_i) |=> $stable(code_q));

  p_tmr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.clr_n && ctrl_q.upd && tick_i) |=> (code_q == $past(pend_q)));

  p_rng_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(range_o));
endmodule

// File: rtl/dac_bank_rdmux.sv
module dac_bank_rdmux
  import dac_bank_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned CODE_LSB = 16,
  localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  rd_en_i,
  input  logic                  hit_i,
  input  logic                  is_data_i,
  input  logic [CH_W-1:0]       ch_i,
  input  ctrl_t [NCH-1:0]       ctrl_i,
  input  logic [NCH*CODE_W-1:0] pend_i,
  output logic [DW-1:0]         rdata_o
);
  logic [NCH-1:0][DW-1:0] ctrl_word;
  logic [NCH-1:0][DW-1:0] data_word;

  for (genvar c = 0; c < NCH; c++) begin : g_word
    always_comb begin
      ctrl_word[c] = '0;
      ctrl_word[c][CTRL_UPD_BIT] = ctrl_i[c].upd;
      ctrl_word[c][CTRL_CLR_BIT] = ctrl_i[c].clr_n;
      ctrl_word[c][CTRL_RNG_LSB +: 2] = ctrl_i[c].rng;
      data_word[c] = '0;
      data_word[c][CODE_LSB +: CODE_W] = pend_i[c*CODE_W +: CODE_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && hit_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_i == CH_W'(c)) rdata_o = is_data_i ? data_word[c] : ctrl_word[c];
      end
    end
  end
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
  import dac_bank_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DW       = 32,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned CODE_LSB = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic                  tick_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH*2-1:0]      range_o,
  output logic [NCH-1:0]        oe_o
);
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                  hit, is_data;
  logic [CH_W-1:0]       ch;
  logic [NCH-1:0]        ctrl_we, data_we;
  ctrl_t                 wr_ctrl;
  logic [CODE_W-1:0]     wr_code;
  ctrl_t [NCH-1:0]       ctrl_st;
  logic [NCH*CODE_W-1:0] pend_st;
  logic                  unused_wdata;

  assign wr_ctrl.upd   = wdata_i[CTRL_UPD_BIT];
  assign wr_ctrl.clr_n = wdata_i[CTRL_CLR_BIT];
  assign wr_ctrl.rng   = rng_e'(wdata_i[CTRL_RNG_LSB +: 2]);
  assign wr_code       = wdata_i[CODE_LSB +: CODE_W];
  assign unused_wdata  = ^{wdata_i[DW-1:CODE_LSB+CODE_W], wdata_i[CODE_LSB-1:CTRL_W],
                           wdata_i[CTRL_W-1:CTRL_UPD_BIT+1], wdata_i[CTRL_CLR_BIT-1:2]};

  dac_bank_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .hit_o    (hit),
    .is_data_o(is_data),
    .ch_o     (ch),
    .ctrl_we_o(ctrl_we),
    .data_we_o(data_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_bank_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(ctrl_we[c]),
      .ctrl_i   (wr_ctrl),
      .data_we_i(data_we[c]),
      .code_i   (wr_code),
      .tick_i   (tick_i),
      .ctrl_o   (ctrl_st[c]),
      .pend_o   (pend_st[c*CODE_W +: CODE_W]),
      .code_o   (code_o[c*CODE_W +: CODE_W]),
      .range_o  (range_o[c*2 +: 2]),
      .oe_o     (oe_o[c])
    );
  end

  dac_bank_rdmux #(.NCH(NCH), .DW(DW), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_rdmux (
    .rd_en_i  (req_i && !we_i),
    .hit_i    (hit),
    .is_data_i(is_data),
    .ch_i     (ch),
    .ctrl_i   (ctrl_st),
    .pend_i   (pend_st),
    .rdata_o  (rdata_o)
  );

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_we, data_we}));

  p_rd_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |-> (rdata_o == '0));

  p_rd_rsvd_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !is_data) |->
      (rdata_o[DW-1:CTRL_UPD_BIT+1] == '0) && (rdata_o[CTRL_CLR_BIT-1:2] == '0));

  p_rd_rsvd_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && is_data) |->
      (rdata_o[DW-1:CODE_LSB+CODE_W] == '0) && (rdata_o[CODE_LSB-1:0] == '0));
endmodule

// File: tb/dac_bank_ctrl_bench.sv
module dac_bank_ctrl_bench;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [47:0] code;
  logic [7:0]  rng;
  logic [3:0]  oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]  exp_ctrl [NCH];
  logic [11:0] exp_pend [NCH];
  logic [11:0] exp_code [NCH];

  always #5 clk = ~clk;

  dac_bank_ctrl u_dac_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .code_o(code), .range_o(rng), .oe_o(oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic tk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; tick = tk;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check_chan(input int c, input string tag);
    logic [31:0] v;
    rd(6'(c*8), v);     chk({tag, " ctrl"}, v, {24'h0, exp_ctrl[c]});
    rd(6'(c*8 + 4), v); chk({tag, " data"}, v, {4'h0, exp_pend[c], 16'h0});
    chk({tag, " code"}, 32'(code[c*12 +: 12]), 32'(exp_code[c]));
    chk({tag, " range"}, 32'(rng[c*2 +: 2]), 32'(exp_ctrl[c][1:0]));
    chk({tag, " oe"}, 32'(oe[c]), 32'(exp_ctrl[c][1:0] != 2'b00));
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) check_chan(c, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [11:0] cv;
    for (int c = 0; c < NCH; c++) begin exp_ctrl[c] = '0; exp_pend[c] = '0; exp_code[c] = '0; end
    @(negedge clk); @(negedge clk);
    check_all("R1 reset");
    rst_ni = 1'b1;
    idle(1);
    check_all("R1 after release");

    // R4: write while clear bit is 0 after reset
    wr(6'h04, 32'h0ABC_0000, 1'b0);
    idle(1);
    check_chan(0, "R4 write during clear");

    // R2 R3 R8: full control-word sweep per channel
    for (int c = 0; c < NCH; c++) begin
      for (int val = 0; val < 256; val++) begin
        wr(6'(c*8), 32'hFFFF_FF00 | 32'(val), 1'b0);
        exp_ctrl[c] = 8'(val) & 8'h33;
        rd(6'(c*8), v);
        chk("R2 R3 ctrl readback", v, {24'h0, exp_ctrl[c]});
        chk("R8 range", 32'(rng[c*2 +: 2]), 32'(val & 3));
        chk("R8 oe", 32'(oe[c]), 32'((val & 3) != 0));
      end
    end
    idle(1);
    check_all("R10 after sweep");

    // R5: immediate mode, several codes per channel
    for (int c = 0; c < NCH; c++) begin
      wr(6'(c*8), 32'h0000_00DC | 32'(c), 1'b0);  // clr=1 upd=0, reserved bits set
      exp_ctrl[c] = 8'h10 | 8'(c);
      for (int k = 0; k < 8; k++) begin
        cv = (k == 0) ? 12'h000 : (k == 7) ? 12'hFFF : 12'((c*1031 + k*577 + 1) % 4096);
        wr(6'(c*8 + 4), 32'hF000_FFFF | (32'(cv) << 16), 1'b0);
        exp_pend[c] = cv;
        rd(6'(c*8 + 4), v);
        chk("R3 data readback", v, {4'h0, cv, 16'h0});
        chk("R5 code lags one edge", 32'(code[c*12 +: 12]), 32'(exp_code[c]));
        idle(1);
        exp_code[c] = cv;
        chk("R5 code follows", 32'(code[c*12 +: 12]), 32'(cv));
      end
    end
    check_all("R10 after immediate");

    // R6: timer mode on channel 2
    wr(6'h10, 32'h0000_0033, 1'b0);
    exp_ctrl[2] = 8'h33;
    wr(6'h14, 32'h0123_0000, 1'b0);
    wr(6'h14, 32'h0456_0000, 1'b0);
    exp_pend[2] = 12'h456;
    idle(3);
    check_chan(2, "R6 hold before tick");
    tick = 1'b1; idle(1); tick = 1'b0;
    exp_code[2] = 12'h456;
    check_all("R6 R10 after tick");

    // R7: write and tick in the same cycle
    wr(6'h14, 32'h0789_0000, 1'b0);
    exp_pend[2] = 12'h789;
    wr(6'h14, 32'h0ABC_0000, 1'b1);
    exp_code[2] = 12'h789; exp_pend[2] = 12'hABC;
    check_chan(2, "R7 collision");
    idle(2);
    check_chan(2, "R7 new value still pending");
    tick = 1'b1; idle(1); tick = 1'b0;
    exp_code[2] = 12'hABC;
    check_chan(2, "R7 next tick");

    // R4: clear in timer mode, no tick needed
    wr(6'h10, 32'h0000_0023, 1'b0);
    exp_ctrl[2] = 8'h23;
    idle(1);
    exp_pend[2] = '0; exp_code[2] = '0;
    check_chan(2, "R4 clear forces zero");
    wr(6'h14, 32'h0555_0000, 1'b0);
    idle(1);
    check_chan(2, "R4 write ignored during clear");
    wr(6'h10, 32'h0000_0032, 1'b0);
    exp_ctrl[2] = 8'h32;
    wr(6'h14, 32'h0321_0000, 1'b0);
    exp_pend[2] = 12'h321;
    idle(1);
    check_chan(2, "R6 restored timer holds");
    tick = 1'b1; idle(1); tick = 1'b0;
    exp_code[2] = 12'h321;
    check_all("R6 R10 restored tick");

    // R9: unmapped accesses
    foreach (exp_ctrl[i]) begin end
    for (int k = 0; k < 8; k++) begin
      logic [5:0] ua;
      case (k)
        0: ua = 6'h01; 1: ua = 6'h02; 2: ua = 6'h07; 3: ua = 6'h15;
        4: ua = 6'h20; 5: ua = 6'h24; 6: ua = 6'h3C; default: ua = 6'h3F;
      endcase
      wr(ua, 32'hFFFF_FFFF, 1'b0);
      rd(ua, v);
      chk("R9 unmapped read", v, 32'h0);
    end
    idle(1);
    check_all("R9 registers untouched");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule